// File: doc/BRIEF.md
# Hardware Context Recency Tracker

This block follows the issue history of the hardware thread contexts of a multithreaded core. It keeps every user context in a list ordered by recency. Each cycle it reports the context that has gone longest without issuing an instruction. That context is the background spill target. Its dirty registers are written to its swap page one per cycle, and only in cycles where the memory port has nothing else to do. Context 0 runs the event kernel. It is left out of the list, so it is never a spill or suspension candidate.

The block also watches for a stuck core. When no context at all can issue and the least recent context has nothing left to spill, the block raises a one-cycle stall event. Whether to suspend a thread is the kernel's decision, and the block never suspends anything itself. Per-register dirty state is kept inside the block. A register write sets the bit for that register, and a completed spill of that register clears it.

Top module: `ctx_lri_tracker`

## Requirements
- R1: After reset, every register of every context is clean, the recency list from least to most recent is contexts 1,2,...,7 (so `lri_ctx_o` = 1), `stall_o` = 0, and `dribble_req_o` = 0 even with `mem_free_i` = 1.
- R2: When `issue_valid_i` is 1 with a context c other than 0, c becomes the most recent entry from the next cycle on. The other contexts keep their relative order, and `lri_ctx_o` shows the least recent entry.
- R3: An issue by context 0 leaves the recency list unchanged.
- R4: A register write (`wr_valid_i`, `wr_ctx_i`, `wr_reg_i`) marks that register dirty. `dribble_req_o` is 1 in a cycle only if `mem_free_i` = 1 and the context on `lri_ctx_o` has a dirty register. `dribble_reg_o` is then the lowest-numbered dirty register of that context.
- R5: A spill cycle (`dribble_req_o` = 1) clears the dirty bit of `dribble_reg_o` at the clock edge, unless the same register of the same context is written in that cycle, in which case it stays dirty.
- R6: Dirty registers of contexts other than the one on `lri_ctx_o` never produce a spill request.
- R7: When `ready_i` is all zero (context 0 included) and the least recent context is clean in a cycle, `stall_o` is 1 for exactly one cycle, starting the cycle after.
- R8: No stall event is raised while the least recent context has a dirty register, even if nothing can issue.
- R9: After a stall event, no further stall event occurs until some context issues. After an issue, the condition of R7 raises a new event.
- R10: `lri_ctx_o` is never 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | 8 | Per-context can-issue flags, bit n for context n |
| issue_valid_i | input | 1 | A context issued this cycle |
| issue_ctx_i | input | 3 | Context that issued |
| wr_valid_i | input | 1 | Register write this cycle |
| wr_ctx_i | input | 3 | Context of the register write |
| wr_reg_i | input | 4 | Register index written |
| mem_free_i | input | 1 | Memory port is unused this cycle |
| lri_ctx_o | output | 3 | Least recently issued user context |
| dribble_req_o | output | 1 | Spill one register of `lri_ctx_o` this cycle |
| dribble_reg_o | output | 4 | Register to spill |
| stall_o | output | 1 | One-cycle stall event to the kernel |

## Verification
The stall checks assume that an issue only happens from a context whose ready flag is set. An issue in a cycle with `ready_i` all zero would re-arm the event in the same cycle that fires it. The bench drives `ready_i` all ones whenever it issues and clears it only in idle cycles. The properties also assume that `issue_ctx_i` and `wr_ctx_i` name existing contexts, and the bench keeps every index in range. The spill-clear property only looks at cycles without a colliding write, and the bench exercises the colliding case on its own.

// File: rtl/lri_pkg.sv
package lri_pkg;
  localparam int unsigned KERNEL_CTX = 0;

  // lowest set bit index of a vector of up to 64 bits
  function automatic logic [5:0] lowest_set(input logic [63:0] v);
    logic [5:0] idx;
    idx = '0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) idx = 6'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/lri_order.sv
module lri_order import lri_pkg::*; #(
  parameter int unsigned NUM_CTX = 8,
  localparam int unsigned CW = $clog2(NUM_CTX)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_valid_i,
  input  logic [CW-1:0] issue_ctx_i,
  output logic [CW-1:0] lri_ctx_o
);
  localparam int unsigned SLOTS = NUM_CTX - 1;

  // slot 0 is least recent, slot SLOTS-1 most recent
  logic [CW-1:0]    order_q [SLOTS];
  logic [CW-1:0]    order_d [SLOTS];
  logic [SLOTS-1:0] above;
  logic             move;

  always_comb begin
    move     = issue_valid_i && (issue_ctx_i != CW'(KERNEL_CTX));
    above[0] = (order_q[0] == issue_ctx_i);
    for (int i = 1; i < SLOTS; i++) begin
      above[i] = above[i-1] | (order_q[i] == issue_ctx_i);
    end
    for (int i = 0; i < SLOTS - 1; i++) begin
      order_d[i] = (move && above[i]) ? order_q[i+1] : order_q[i];
    end
    order_d[SLOTS-1] = move ? issue_ctx_i : order_q[SLOTS-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SLOTS; i++) order_q[i] <= CW'(i + 1);
    end else begin
      for (int i = 0; i < SLOTS; i++) order_q[i] <= order_d[i];
    end
  end

  assign lri_ctx_o = order_q[0];

  logic [NUM_CTX-1:0] present;
  always_comb begin
    present = '0;
    for (int i = 0; i < SLOTS; i++) present[order_q[i]] = 1'b1;
  end

  // R2
  issue_to_mru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    move |=> (order_q[SLOTS-1] == $past(issue_ctx_i)));
  // R2
  order_perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(present) == SLOTS) && !present[KERNEL_CTX]);
  // R3
  kernel_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && !move) |=> $stable(order_q[0]) && $stable(order_q[SLOTS-1]));
endmodule

// File: rtl/lri_dirty_map.sv
module lri_dirty_map import lri_pkg::*; #(
  parameter int unsigned NUM_CTX  = 8,
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned CW = $clog2(NUM_CTX),
  localparam int unsigned RW = $clog2(NUM_REGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [CW-1:0] wr_ctx_i,
  input  logic [RW-1:0] wr_reg_i,
  input  logic [CW-1:0] lri_ctx_i,
  input  logic          mem_free_i,
  output logic          lri_clean_o,
  output logic          drib_req_o,
  output logic [RW-1:0] drib_reg_o
);
  localparam int unsigned TOT = NUM_CTX * NUM_REGS;
  localparam int unsigned IW  = $clog2(TOT);

  logic [TOT-1:0]      dirty_q;
  logic [NUM_REGS-1:0] lri_row;
  logic [IW-1:0]       wr_idx, drib_idx;
  logic [TOT-1:0]      set_v, clr_v;

  assign lri_row     = dirty_q[lri_ctx_i * NUM_REGS +: NUM_REGS];
  assign lri_clean_o = ~|lri_row;
  assign drib_req_o  = mem_free_i && !lri_clean_o;
  assign drib_reg_o  = RW'(lowest_set(64'(lri_row)));

  assign wr_idx   = IW'(wr_ctx_i) * IW'(NUM_REGS) + IW'(wr_reg_i);
  assign drib_idx = IW'(lri_ctx_i) * IW'(NUM_REGS) + IW'(drib_reg_o);

  always_comb begin
    set_v = '0;
    clr_v = '0;
    if (wr_valid_i) set_v[wr_idx] = 1'b1;
    if (drib_req_o) clr_v[drib_idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dirty_q <= '0;
    else         dirty_q <= (dirty_q & ~clr_v) | set_v;
  end

  // R4
  write_marks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> dirty_q[$past(wr_idx)]);
  // R5
  spill_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drib_req_o && !(wr_valid_i && wr_idx == drib_idx)) |=> !dirty_q[$past(drib_idx)]);
  // R5
  spill_collide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drib_req_o && wr_valid_i && wr_idx == drib_idx) |=> dirty_q[$past(drib_idx)]);
endmodule

// File: rtl/lri_stall_gen.sv
module lri_stall_gen #(
  parameter int unsigned NUM_CTX = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CTX-1:0] ready_i,
  input  logic               issue_valid_i,
  input  logic               lri_clean_i,
  output logic               stall_o
);
  logic armed_q, stall_q, fire;

  assign fire = (ready_i == '0) && lri_clean_i && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      stall_q <= 1'b0;
    end else begin
      stall_q <= fire;
      if (issue_valid_i) armed_q <= 1'b1;
      else if (fire)     armed_q <= 1'b0;
    end
  end

  assign stall_o = stall_q;

  // R7
  stall_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_q |=> !stall_q);
  // R7
  stall_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_q |-> $past(ready_i == '0));
  // R8
  stall_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_q |-> $past(lri_clean_i));
endmodule

// File: rtl/ctx_lri_tracker.sv
module ctx_lri_tracker import lri_pkg::*; #(
  parameter int unsigned NUM_CTX  = 8,
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned CW = $clog2(NUM_CTX),
  localparam int unsigned RW = $clog2(NUM_REGS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CTX-1:0] ready_i,
  input  logic               issue_valid_i,
  input  logic [CW-1:0]      issue_ctx_i,
  input  logic               wr_valid_i,
  input  logic [CW-1:0]      wr_ctx_i,
  input  logic [RW-1:0]      wr_reg_i,
  input  logic               mem_free_i,
  output logic [CW-1:0]      lri_ctx_o,
  output logic               dribble_req_o,
  output logic [RW-1:0]      dribble_reg_o,
  output logic               stall_o
);
  logic [CW-1:0] lri_ctx;
  logic          lri_clean;

  lri_order #(.NUM_CTX(NUM_CTX)) i_order (
    .clk_i, .rst_ni,
    .issue_valid_i, .issue_ctx_i,
    .lri_ctx_o (lri_ctx)
  );

  lri_dirty_map #(.NUM_CTX(NUM_CTX), .NUM_REGS(NUM_REGS)) i_dirty (
    .clk_i, .rst_ni,
    .wr_valid_i, .wr_ctx_i, .wr_reg_i,
    .lri_ctx_i   (lri_ctx),
    .mem_free_i,
    .lri_clean_o (lri_clean),
    .drib_req_o  (dribble_req_o),
    .drib_reg_o  (dribble_reg_o)
  );

  lri_stall_gen #(.NUM_CTX(NUM_CTX)) i_stall (
    .clk_i, .rst_ni,
    .ready_i, .issue_valid_i,
    .lri_clean_i (lri_clean),
    .stall_o
  );

  assign lri_ctx_o = lri_ctx;

  // R10
  lri_not_kernel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lri_ctx_o != CW'(KERNEL_CTX));
endmodule

// File: tb/test_ctx_lri_tracker.sv
`timescale 1ns/100ps
module test_ctx_lri_tracker;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] ready_i = 8'hFF;
  logic       issue_valid_i = 1'b0;
  logic [2:0] issue_ctx_i = '0;
  logic       wr_valid_i = 1'b0;
  logic [2:0] wr_ctx_i = '0;
  logic [3:0] wr_reg_i = '0;
  logic       mem_free_i = 1'b0;
  logic [2:0] lri_ctx_o;
  logic       dribble_req_o;
  logic [3:0] dribble_reg_o;
  logic       stall_o;

  int checks = 0;
  int errors = 0;
  int lst [7];

  always #2.5 clk_i = ~clk_i;

  ctx_lri_tracker i_ctx_lri_tracker (.*);

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic model_issue(int c);
    int p;
    if (c == 0) return;
    p = 0;
    for (int i = 0; i < 7; i++) if (lst[i] == c) p = i;
    for (int i = p; i < 6; i++) lst[i] = lst[i+1];
    lst[6] = c;
  endtask

  task automatic do_issue(int c, string tag);
    issue_valid_i = 1'b1;
    issue_ctx_i   = 3'(c);
    tick();
    issue_valid_i = 1'b0;
    model_issue(c);
    check(tag, int'(lri_ctx_o), lst[0]);
    check("R10 lri not kernel", int'(lri_ctx_o != 0), 1);
  endtask

  task automatic do_write(int c, int r);
    wr_valid_i = 1'b1;
    wr_ctx_i   = 3'(c);
    wr_reg_i   = 4'(r);
    tick();
    wr_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 7; i++) lst[i] = i + 1;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    #1;
    check("R1 reset lri", int'(lri_ctx_o), 1);
    check("R1 reset stall", int'(stall_o), 0);
    mem_free_i = 1'b1;
    #1;
    check("R1 reset clean", int'(dribble_req_o), 0);
    mem_free_i = 1'b0;
  endtask

  task automatic t_order();
    do_issue(1, "R2 issue 1");
    do_issue(2, "R2 issue 2");
    do_issue(5, "R2 issue 5");
    do_issue(3, "R2 issue 3");
    do_issue(0, "R3 kernel issue");
    do_issue(7, "R2 issue mru 7");
    do_issue(4, "R2 issue tail 4");
  endtask

  task automatic t_dribble();
    int l;
    l = lst[0];
    do_write(l, 5);
    do_write(l, 2);
    do_write(2, 0);
    #1;
    check("R4 no free slot", int'(dribble_req_o), 0);
    mem_free_i = 1'b1;
    #1;
    check("R4 spill req", int'(dribble_req_o), 1);
    check("R4 lowest reg", int'(dribble_reg_o), 2);
    tick();
    check("R5 next reg req", int'(dribble_req_o), 1);
    check("R5 next reg", int'(dribble_reg_o), 5);
    tick();
    check("R5 row clean", int'(dribble_req_o), 0);
    check("R6 other ctx ignored", int'(dribble_req_o), 0);
    mem_free_i = 1'b0;
    do_issue(6, "R2 issue 6");
    do_issue(1, "R2 issue 1 again");
    mem_free_i = 1'b1;
    #1;
    check("R6 follows lri req", int'(dribble_req_o), 1);
    check("R6 follows lri reg", int'(dribble_reg_o), 0);
    tick();
    check("R5 ctx2 clean", int'(dribble_req_o), 0);
    mem_free_i = 1'b0;
    // collision
    do_write(lst[0], 3);
    wr_valid_i = 1'b1;
    wr_ctx_i   = 3'(lst[0]);
    wr_reg_i   = 4'd3;
    mem_free_i = 1'b1;
    #1;
    check("R5 collide req", int'(dribble_reg_o), 3);
    tick();
    wr_valid_i = 1'b0;
    #1;
    check("R5 collide kept", int'(dribble_req_o), 1);
    check("R5 collide kept reg", int'(dribble_reg_o), 3);
    tick();
    check("R5 collide cleared", int'(dribble_req_o), 0);
    mem_free_i = 1'b0;
  endtask

  task automatic t_stall();
    ready_i = 8'h01;
    tick();
    tick();
    check("R7 kernel ready no stall", int'(stall_o), 0);
    ready_i = 8'h00;
    tick();
    check("R7 stall raised", int'(stall_o), 1);
    tick();
    check("R7 stall one cycle", int'(stall_o), 0);
    tick();
    tick();
    check("R9 no refire", int'(stall_o), 0);
    ready_i = 8'hFF;
    do_issue(5, "R2 issue 5 rearm");
    do_write(lst[0], 7);
    ready_i = 8'h00;
    tick();
    check("R8 dirty no stall", int'(stall_o), 0);
    tick();
    check("R8 dirty no stall later", int'(stall_o), 0);
    mem_free_i = 1'b1;
    tick();
    mem_free_i = 1'b0;
    check("R8 spill cycle no stall", int'(stall_o), 0);
    tick();
    check("R9 refire after issue", int'(stall_o), 1);
    tick();
    check("R9 refire pulse", int'(stall_o), 0);
    ready_i = 8'hFF;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_order();
    t_dribble();
    t_stall();
    tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule